// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the software-visible front end of a multi-channel event timer. It sits on a simple 32-bit register bus. It holds a read-only capability word pair, a general configuration register with a global enable and a legacy-route flag, and a channel interrupt status view. It also owns the 64-bit main counter. While the global enable is set, the counter advances by one on every cycle in which `tick` is high. While the enable is clear, the counter holds its value.

Each channel has a 32-byte register window. Accesses that fall inside the window of a configured channel are forwarded combinationally to the channel logic, which lies outside this block. The channel logic must return read data on `ch_rdata` within the same cycle, as a function of `ch_idx` and `ch_off`. Edges of the global enable are turned into one-cycle re-arm and disarm strobes per channel. Writing ones to the status register produces one-cycle clear strobes. The status bits themselves belong to the channels, so a bit drops only when its channel deasserts it.

The bus has no back-pressure. Every access is accepted in the cycle where `bus_valid` is high. A read returns its data with `bus_rvalid` exactly one cycle later. The channel count parameter is clamped into the range 3..32 before use.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, `count` is zero, `cfg_enable`, `cfg_legacy`, `bus_rvalid` and all `ch_arm`/`ch_disarm`/`ch_irq_clr` bits are zero, and `bus_rdata` is zero.
- R2: A read at byte offset 0x000 returns 0x8086A001 with (channels - 1) added into the 5-bit field at bits 12:8. A read at 0x004 returns the parameter `TICK_FS`, the tick period in femtoseconds.
- R3: The general configuration is at 0x010. Only bit 0 (enable) and bit 1 (legacy route) store a write, and all other bits read zero. Writes to the upper word at 0x014 are ignored, and that word reads zero.
- R4: While enabled, `count` rises by one on each cycle with `tick` high, including the carry from the low word into the high word. While disabled, it holds regardless of `tick`.
- R5: The counter low word (0x0F0) and high word (0x0F4) read the current value and are writable whether or not the block is enabled. In the cycle of a counter write, the written half replaces that half and no increment takes place.
- R6: One cycle after the enable goes from 0 to 1, `ch_arm[n]` pulses for exactly one cycle for every channel n whose `ch_cmp_max[n]` is low.
- R7: One cycle after the enable goes from 1 to 0, every bit of `ch_disarm` pulses for exactly one cycle.
- R8: A read at 0x020 returns `ch_irq_status` in bits NCH-1:0 and zeros elsewhere. A write there drives `ch_irq_clr = wdata & ch_irq_status` during the write cycle.
- R9: An access to byte address 0x100 + n*0x20 + k, with n below the clamped channel count, drives `ch_req` high during the access cycle together with `ch_idx = n`, `ch_off = k`, `ch_we` and `ch_wdata`. For reads, the `ch_rdata` value from that cycle is returned.
- R10: Addresses that are not mapped, and channel windows at or beyond the clamped count, read as zero. Writes to them, and to the capability words, change no state and raise no `ch_req`.
- R11: `bus_rvalid` is high exactly in the cycle after a read request, and `bus_rdata` is zero when `bus_rvalid` is low.
- R12: `NUM_CH` below 3 or above 32 is clamped to that range. The capability field and the channel vectors use the clamped count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request, one per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (32-bit aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| tick | input | 1 | Counter advance strobe |
| count | output | 64 | Main counter value |
| cfg_enable | output | 1 | Global enable |
| cfg_legacy | output | 1 | Legacy routing flag |
| ch_irq_status | input | NCH | Per-channel interrupt status |
| ch_irq_clr | output | NCH | Write-one-to-clear strobes |
| ch_cmp_max | input | NCH | Channel comparator is all ones |
| ch_arm | output | NCH | Re-arm strobe on enable rise |
| ch_disarm | output | NCH | Disarm strobe on enable fall |
| ch_req | output | 1 | Channel window access |
| ch_we | output | 1 | Channel access is a write |
| ch_idx | output | IDX_W | Channel index |
| ch_off | output | 5 | Byte offset inside the window |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32 | Channel read data, same cycle |

## Verification
A wrong enable register or a wrong edge detector shows at `ch_arm`/`ch_disarm` within one cycle of the configuration write. A counter that advances when it should hold becomes visible at the next read of 0x0F0, because the bench gates `tick` to a known number of cycles. A decode fault moves data between regions or raises `ch_req` on a foreign address. The sweep over every word address exposes this on the exact read that lands in the wrong region, one cycle after the request.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
  localparam int CH_MIN     = 3;
  localparam int CH_MAX     = 32;
  localparam int CNT_W      = 64;
  localparam int WORD_W     = 32;
  localparam int OFF_CAP    = 'h000;
  localparam int OFF_GCFG   = 'h010;
  localparam int OFF_STS    = 'h020;
  localparam int OFF_CNT    = 'h0F0;
  localparam int CH_BASE    = 'h100;
  localparam int CH_WIN_LG  = 5;
  localparam int CAP_FLD_LSB = 8;
  localparam logic [31:0] CAP_BASE = 32'h8086_A001;
  localparam logic [31:0] GCFG_WMASK = 32'h0000_0003;

  typedef enum logic [2:0] {
    RG_NONE, RG_CAP, RG_GCFG, RG_STS, RG_CNT, RG_CHAN
  } region_e;

  function automatic int clamp_ch(input int n);
    if (n < CH_MIN) return CH_MIN;
    if (n > CH_MAX) return CH_MAX;
    return n;
  endfunction
endpackage

// File: rtl/evt_addr_dec.sv
`timescale 1ns/1ps
module evt_addr_dec
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NCH    = 3,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              hi_word,
  output logic [IDX_W-1:0]  ch_idx,
  output logic [4:0]        ch_off
);
  logic [ADDR_W-1:0] pair;
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] raw_idx;

  always_comb begin
    pair    = {addr[ADDR_W-1:3], 3'b000};
    hi_word = addr[2];
    rel     = addr - ADDR_W'(CH_BASE);
    raw_idx = rel >> CH_WIN_LG;
    ch_off  = rel[4:0];
    ch_idx  = raw_idx[IDX_W-1:0];
    region  = RG_NONE;
    if (pair == ADDR_W'(OFF_CAP))       region = RG_CAP;
    else if (pair == ADDR_W'(OFF_GCFG)) region = RG_GCFG;
    else if (pair == ADDR_W'(OFF_STS))  region = RG_STS;
    else if (pair == ADDR_W'(OFF_CNT))  region = RG_CNT;
    else if (addr >= ADDR_W'(CH_BASE) && raw_idx < ADDR_W'(NCH))
      region = RG_CHAN;
  end
endmodule

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W/2-1:0] wdata,
  output logic [W-1:0] count
);
  localparam int HW = W / 2;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = count;
    if (wr_lo || wr_hi) begin
      if (wr_lo) nxt[HW-1:0] = wdata;
      if (wr_hi) nxt[W-1:HW] = wdata;
    end else if (run && tick) begin
      nxt = count + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end
endmodule

// File: rtl/evt_gen_cfg.sv
`timescale 1ns/1ps
module evt_gen_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wbits,
  output logic       enable,
  output logic       legacy,
  output logic       rise,
  output logic       fall
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      legacy <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= enable;
      if (wr_en) begin
        enable <= wbits[0];
        legacy <= wbits[1];
      end
    end
  end

  assign rise = enable & ~en_q;
  assign fall = ~enable & en_q;
endmodule

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  localparam int         NCH     = clamp_ch(NUM_CH),
  localparam int         IDX_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  input  logic              tick,
  output logic [63:0]       count,
  output logic              cfg_enable,
  output logic              cfg_legacy,
  input  logic [NCH-1:0]    ch_irq_status,
  output logic [NCH-1:0]    ch_irq_clr,
  input  logic [NCH-1:0]    ch_cmp_max,
  output logic [NCH-1:0]    ch_arm,
  output logic [NCH-1:0]    ch_disarm,
  output logic              ch_req,
  output logic              ch_we,
  output logic [IDX_W-1:0]  ch_idx,
  output logic [4:0]        ch_off,
  output logic [31:0]       ch_wdata,
  input  logic [31:0]       ch_rdata
);
  localparam logic [31:0] CAP_LO = CAP_BASE | (32'(NCH - 1) << CAP_FLD_LSB);

  region_e     reg_sel;
  logic        hi_word;
  logic        wr_acc, rd_acc;
  logic        cfg_wr, cnt_wr_lo, cnt_wr_hi, sts_wr;
  logic        en_rise, en_fall;
  logic [31:0] rd_c;

  evt_addr_dec #(.ADDR_W(ADDR_W), .NCH(NCH), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .region(reg_sel), .hi_word(hi_word),
    .ch_idx(ch_idx), .ch_off(ch_off)
  );

  assign wr_acc    = bus_valid & bus_write;
  assign rd_acc    = bus_valid & ~bus_write;
  assign cfg_wr    = wr_acc & (reg_sel == RG_GCFG) & ~hi_word;
  assign cnt_wr_lo = wr_acc & (reg_sel == RG_CNT) & ~hi_word;
  assign cnt_wr_hi = wr_acc & (reg_sel == RG_CNT) & hi_word;
  assign sts_wr    = wr_acc & (reg_sel == RG_STS) & ~hi_word;

  evt_gen_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
    .wbits(bus_wdata[1:0] & GCFG_WMASK[1:0]),
    .enable(cfg_enable), .legacy(cfg_legacy),
    .rise(en_rise), .fall(en_fall)
  );

  evt_main_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg_enable), .tick(tick),
    .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi), .wdata(bus_wdata),
    .count(count)
  );

  // per-channel strobe lanes
  for (genvar n = 0; n < NCH; n++) begin : g_lane
    assign ch_arm[n]     = en_rise & ~ch_cmp_max[n];
    assign ch_disarm[n]  = en_fall;
    assign ch_irq_clr[n] = sts_wr & bus_wdata[n] & ch_irq_status[n];
  end

  assign ch_req   = bus_valid & (reg_sel == RG_CHAN);
  assign ch_we    = bus_write;
  assign ch_wdata = bus_wdata;

  always_comb begin
    rd_c = '0;
    unique case (reg_sel)
      RG_CAP:  rd_c = hi_word ? TICK_FS : CAP_LO;
      RG_GCFG: rd_c = hi_word ? 32'd0 : {30'd0, cfg_legacy, cfg_enable};
      RG_STS:  rd_c = hi_word ? 32'd0 : 32'(ch_irq_status);
      RG_CNT:  rd_c = hi_word ? count[63:32] : count[31:0];
      RG_CHAN: rd_c = ch_rdata;
      default: rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_acc;
      bus_rdata  <= rd_acc ? rd_c : 32'd0;
    end
  end
endmodule

// File: rtl/evt_timer_regs_chk.sv
`timescale 1ns/1ps
module evt_timer_regs_chk
  import evt_timer_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             bus_rvalid,
  input logic [31:0]      bus_rdata,
  input region_e          reg_sel,
  input logic             hi_word,
  input logic             tick,
  input logic             cnt_wr,
  input logic [63:0]      count,
  input logic             cfg_enable,
  input logic [NCH-1:0]   ch_arm,
  input logic [NCH-1:0]   ch_disarm,
  input logic [NCH-1:0]   ch_irq_clr,
  input logic [NCH-1:0]   ch_irq_status,
  input logic             ch_req,
  input logic [IDX_W-1:0] ch_idx
);
  p_cfghi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && reg_sel == RG_GCFG && hi_word) |=> (bus_rdata == 32'd0));

  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && tick && !cnt_wr) |=> (count == $past(count) + 64'd1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !cnt_wr) |=> $stable(count));

  p_arm_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_arm != '0) |-> (cfg_enable && !$past(cfg_enable)));

  p_disarm_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_disarm != '0) |-> (!cfg_enable && $past(cfg_enable)));

  p_clr_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_irq_clr & ~ch_irq_status) == '0));

  p_req_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req |-> (int'(ch_idx) < NCH));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && reg_sel == RG_NONE) |=> (bus_rdata == 32'd0));

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .reg_sel(reg_sel),
  .hi_word(hi_word), .tick(tick), .cnt_wr(cnt_wr_lo | cnt_wr_hi),
  .count(count), .cfg_enable(cfg_enable), .ch_arm(ch_arm),
  .ch_disarm(ch_disarm), .ch_irq_clr(ch_irq_clr),
  .ch_irq_status(ch_irq_status), .ch_req(ch_req), .ch_idx(ch_idx)
);

// File: tb/evt_timer_regs_test.sv
`timescale 1ns/1ps
module evt_timer_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        tick = 1'b0;
  logic [63:0] count;
  logic        cfg_enable, cfg_legacy;
  logic [3:0]  ch_irq_status = 4'b1010, ch_irq_clr, ch_cmp_max = 4'b0100;
  logic [3:0]  ch_arm, ch_disarm;
  logic        ch_req, ch_we;
  logic [1:0]  ch_idx;
  logic [4:0]  ch_off;
  logic [31:0] ch_wdata, ch_rdata;

  assign ch_rdata = 32'hC0DE_0000 | (32'(ch_idx) << 8) | 32'(ch_off);

  evt_timer_regs #(.NUM_CH(4), .ADDR_W(12), .TICK_FS(32'd10_000_000)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .tick(tick), .count(count),
    .cfg_enable(cfg_enable), .cfg_legacy(cfg_legacy),
    .ch_irq_status(ch_irq_status), .ch_irq_clr(ch_irq_clr),
    .ch_cmp_max(ch_cmp_max), .ch_arm(ch_arm), .ch_disarm(ch_disarm),
    .ch_req(ch_req), .ch_we(ch_we), .ch_idx(ch_idx), .ch_off(ch_off),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata)
  );

  // second instance: channel count above the legal range
  logic        w_rvalid, w_en, w_leg, w_req, w_we;
  logic [31:0] w_rdata, w_wdata;
  logic [63:0] w_count;
  logic [31:0] w_clr, w_arm, w_dis;
  logic [4:0]  w_idx, w_off;

  evt_timer_regs #(.NUM_CH(40), .ADDR_W(12)) uut_wide (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(1'b0),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(w_rvalid),
    .bus_rdata(w_rdata), .tick(1'b0), .count(w_count),
    .cfg_enable(w_en), .cfg_legacy(w_leg),
    .ch_irq_status(32'd0), .ch_irq_clr(w_clr),
    .ch_cmp_max(32'd0), .ch_arm(w_arm), .ch_disarm(w_dis),
    .ch_req(w_req), .ch_we(w_we), .ch_idx(w_idx), .ch_off(w_off),
    .ch_wdata(w_wdata), .ch_rdata(32'd0)
  );

  int checks = 0;
  int failures = 0;
  logic [63:0] m_cnt;
  logic [31:0] m_cfg;
  logic        s_req, s_we;
  logic [1:0]  s_idx;
  logic [4:0]  s_off;
  logic [31:0] s_wdata;
  logic [3:0]  s_clr;
  logic [31:0] rd_val, rd_wide;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [11:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 s_req = ch_req;
    @(negedge clk);
    bus_valid = 1'b0;
    rd_val = bus_rdata;
    rd_wide = w_rdata;
    chk("R11 rvalid", {63'd0, bus_rvalid}, 64'd1);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    s_req = ch_req; s_we = ch_we; s_idx = ch_idx; s_off = ch_off;
    s_wdata = ch_wdata; s_clr = ch_irq_clr;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [11:0] pr;
    pr = {a[11:3], 3'b000};
    if (pr == 12'h000) return a[2] ? 32'd10_000_000 : (32'h8086_A001 | (32'(4 - 1) << 8));
    if (pr == 12'h010) return a[2] ? 32'd0 : m_cfg;
    if (pr == 12'h020) return a[2] ? 32'd0 : {28'd0, ch_irq_status};
    if (pr == 12'h0F0) return a[2] ? m_cnt[63:32] : m_cnt[31:0];
    if (a >= 12'h100 && a < 12'h180)
      return 32'hC0DE_0000 | (32'((a - 12'h100) >> 5) << 8) | 32'(a[4:0]);
    return 32'd0;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 64'd0);
    chk("R1 cfg", {62'd0, cfg_legacy, cfg_enable}, 64'd0);
    chk("R1 strobes", {52'd0, ch_arm, ch_disarm, ch_irq_clr}, 64'd0);
    chk("R1 rd", {31'd0, bus_rvalid, bus_rdata}, 64'd0);

    // R2 capability, R12 clamp
    bus_rd(12'h000);
    chk("R2 cap lo", rd_val, 32'h8086_A001 | (32'(3) << 8));
    chk("R12 clamp field", rd_wide, 32'h8086_A001 | (32'(31) << 8));
    bus_rd(12'h004);
    chk("R2 cap hi", rd_val, 32'd10_000_000);

    // R5 counter halves while disabled, R4 hold
    bus_wr(12'h0F0, 32'h9ABC_DEF0);
    bus_wr(12'h0F4, 32'h1234_5678);
    m_cnt = 64'h1234_5678_9ABC_DEF0;
    tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
    bus_rd(12'h0F0); chk("R4 hold lo", rd_val, m_cnt[31:0]);
    bus_rd(12'h0F4); chk("R5 hi written", rd_val, m_cnt[63:32]);

    // R3 config mask and upper word
    bus_wr(12'h010, 32'hFFFF_FFFE);
    m_cfg = 32'd2;
    bus_wr(12'h014, 32'hFFFF_FFFF);
    bus_rd(12'h010); chk("R3 cfg lo", rd_val, 32'd2);
    bus_rd(12'h014); chk("R3 cfg hi", rd_val, 32'd0);

    // R9 R10 R2 R8: read sweep over every word address
    for (int a = 0; a < 4096; a += 4) begin
      bus_rd(12'(a));
      chk((a >= 'h100) ? "R9/R10 sweep" : "R2/R8/R10 sweep",
          {31'd0, s_req, rd_val},
          {31'd0, (a >= 'h100 && a < 'h180), exp_rd(12'(a))});
    end

    // R10: writes to unmapped, read-only and out-of-range addresses
    begin
      int req_hits = 0;
      int clr_hits = 0;
      for (int a = 0; a < 4096; a += 4) begin
        if (a == 'h010 || a == 'h020 || a == 'h0F0 || a == 'h0F4) continue;
        if (a >= 'h100 && a < 'h180) continue;
        bus_wr(12'(a), 32'hFFFF_FFFF);
        if (s_req) req_hits++;
        if (s_clr != 4'd0) clr_hits++;
      end
      chk("R10 no ch_req", 64'(req_hits), 64'd0);
      chk("R10 no clear", 64'(clr_hits), 64'd0);
    end
    bus_rd(12'h010); chk("R10 cfg kept", rd_val, 32'd2);
    bus_rd(12'h0F0); chk("R10 cnt kept", rd_val, m_cnt[31:0]);
    bus_rd(12'h000); chk("R10 cap kept", rd_val, 32'h8086_A301);

    // R9 channel write forwarding
    bus_wr(12'h148, 32'h0000_AA55);
    chk("R9 fwd", {s_req, s_we, s_idx, s_off, s_wdata},
        {1'b1, 1'b1, 2'd2, 5'd8, 32'h0000_AA55});
    bus_wr(12'h190, 32'h1);
    chk("R10 ch beyond count", {63'd0, s_req}, 64'd0);

    // R8 write-one-to-clear
    bus_wr(12'h020, 32'h0000_000F);
    chk("R8 clr", {60'd0, s_clr}, 64'b1010);
    bus_wr(12'h020, 32'h0000_0005);
    chk("R8 clr none", {60'd0, s_clr}, 64'd0);

    // R6 rising enable
    bus_wr(12'h010, 32'h3);
    m_cfg = 32'd3;
    chk("R6 arm", {56'd0, ch_arm, ch_disarm}, {56'd0, 4'b1011, 4'b0000});
    @(negedge clk);
    chk("R6 arm once", {60'd0, ch_arm}, 64'd0);

    // R4 counting
    tick = 1'b1; repeat (7) @(negedge clk); tick = 1'b0;
    m_cnt = m_cnt + 64'd7;
    bus_rd(12'h0F0); chk("R4 count", rd_val, m_cnt[31:0]);

    // R5 write while enabled wins over increment
    bus_wr(12'h0F4, 32'h1234_5678);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h0F0; bus_wdata = 32'd5; tick = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    @(negedge clk);
    tick = 1'b0;
    bus_rd(12'h0F0); chk("R5 write while enabled", rd_val, 32'd6);
    bus_rd(12'h0F4); chk("R5 hi kept", rd_val, 32'h1234_5678);

    // R4 carry into high word
    bus_wr(12'h0F0, 32'hFFFF_FFFF);
    bus_wr(12'h0F4, 32'h0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    bus_rd(12'h0F0); chk("R4 carry lo", rd_val, 32'd0);
    bus_rd(12'h0F4); chk("R4 carry hi", rd_val, 32'd1);

    // R7 falling enable, then hold
    bus_wr(12'h010, 32'h2);
    chk("R7 disarm", {56'd0, ch_arm, ch_disarm}, {56'd0, 4'b0000, 4'b1111});
    @(negedge clk);
    chk("R7 disarm once", {60'd0, ch_disarm}, 64'd0);
    tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    bus_rd(12'h0F4); chk("R4 hold after stop", rd_val, 32'd1);
    bus_rd(12'h0F0); chk("R4 hold lo after stop", rd_val, 32'd0);

    finish_run();
  end
endmodule